// File: doc/BRIEF.md
# Coefficient Shift-Add Pixel Multiplier

This block scales an unsigned pixel by one of two signed coefficients that come from a pair of programmable parameters: a sharpening weight and a smoothing weight. The first coefficient is the sharpening weight minus the smoothing weight. The second coefficient is that same difference less one. The block has no general multiplier. When either parameter is written, the block turns each coefficient's magnitude into a short list of power-of-two terms and keeps that list in registers. For each pixel, the block shifts the pixel by the stored amounts and adds the shifted terms in a chain of adders. A sign stage then negates the sum when the coefficient is negative.

The block sits inside a prefilter datapath. The datapath presents one pixel per clock and picks the coefficient with a one-bit function select. The signed product appears on the output one clock later. Software sets the two parameters through two write strobes. Each parameter keeps its value until it is written again.

Top module: `rpm_unit`

## Requirements
- R1: With func_sel = 0, the prod_out value registered at a clock edge equals (S - C) × pix_in, using the pix_in value sampled at that edge. S and C are the held parameter values.
- R2: With func_sel = 1, the prod_out value registered at a clock edge equals (S - C - 1) × pix_in, using the pix_in value sampled at that edge.
- R3: S and C are unsigned COEF_W-bit values (0..15 by default). Each is loaded at a clock edge where its own strobe (s_we or c_we) is high. A write to one parameter leaves the other unchanged. A pixel sampled at the same edge as a write still uses the old values. A pixel sampled at any later edge uses the new values.
- R4: When the selected coefficient is negative and the pixel is non-zero, prod_out is the two's-complement negative product.
- R5: A zero coefficient (S = C with func_sel = 0) gives prod_out = 0 for every pixel.
- R6: The extreme coefficients are exact. With a pixel of 255, coefficient +15 gives 3825, coefficient -15 gives -3825, and coefficient -16 gives -4080.
- R7: A synchronous active-low reset clears S, C and prod_out to zero. Right after reset, func_sel = 0 gives 0 and func_sel = 1 gives -pix_in.
- R8: pix_in is unsigned PIX_W bits (8 by default). prod_out is signed, PIX_W + COEF_W + 2 bits wide (14 by default), and never goes outside ±(2^PIX_W - 1)·2^COEF_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_in | input | PIX_W | Unsigned source pixel |
| func_sel | input | 1 | 0: coefficient S-C, 1: coefficient S-C-1 |
| s_we | input | 1 | Write strobe for the sharpening weight |
| s_val | input | COEF_W | Sharpening weight write data |
| c_we | input | 1 | Write strobe for the smoothing weight |
| c_val | input | COEF_W | Smoothing weight write data |
| prod_out | output | PIX_W+COEF_W+2 | Signed registered product |

## Verification
The assertions check several properties on every cycle. They check that the stored term lists stay unchanged when no parameter is written. They check that a negative flag always comes with at least one active term. They check that an empty term list gives a zero product, and that the product's sign follows the selected coefficient's sign. They also check that the product stays in range and that reset clears it. The numeric value of each product, the extreme coefficients and the order of a write against a pixel on the same edge can be shown only by the bench. The bench compares these against products it computes itself from the parameters, over the full grid of parameter values.

// File: rtl/rpm_pkg.sv
// Package: shared types for the shift-add coefficient multiplier.
// Assumes no coefficient magnitude needs a shift wider than TERM_SH_W bits.
package rpm_pkg;
    localparam int unsigned TERM_SH_W = 4;

    // One power-of-two term: an enable flag and a left-shift amount.
    typedef struct packed {
        logic                 en;
        logic [TERM_SH_W-1:0] sh;
    } term_t;
endpackage

// File: rtl/coef_decomp.sv
// coef_decomp: combinational. It forms the coefficient s - c - m1 and
// reports its sign. It also splits the coefficient's magnitude into up to
// NTERM power-of-two terms, taking the lowest set bit first.
// Assumes s and c are unsigned and that NTERM >= the popcount of any magnitude.
module coef_decomp
    import rpm_pkg::*;
#(
    parameter int unsigned COEF_W = 4,
    parameter int unsigned NTERM  = COEF_W
) (
    input  logic [COEF_W-1:0] s_in,
    input  logic [COEF_W-1:0] c_in,
    input  logic              m1,
    output logic              neg,
    output term_t [NTERM-1:0] terms
);
    localparam int unsigned DW   = COEF_W + 2;
    localparam int unsigned MAGW = COEF_W + 1;

    logic signed [DW-1:0] diff;
    logic        [DW-1:0] absval;
    logic      [MAGW-1:0] mag;

    // Form the signed coefficient and its magnitude.
    always_comb begin
        diff   = $signed({2'b00, s_in}) - $signed({2'b00, c_in})
               - $signed({{(DW-1){1'b0}}, m1});
        neg    = diff[DW-1];
        absval = neg ? (~diff + 1'b1) : diff;
        mag    = absval[MAGW-1:0];
    end

    // Term k takes the position of the k-th set bit of the magnitude.
    always_comb begin
        terms = '0;
        for (int k = 0; k < NTERM; k++) begin
            int cnt;
            cnt = 0;
            for (int b = 0; b < MAGW; b++) begin
                if (mag[b]) begin
                    if (cnt == k) begin
                        terms[k].en = 1'b1;
                        terms[k].sh = TERM_SH_W'(b);
                    end
                    cnt = cnt + 1;
                end
            end
        end
    end
endmodule

// File: rtl/coef_store.sv
// coef_store: holds both weights and a pre-decomposed term list for each
// of the two coefficient functions. The lists are rebuilt only on a write,
// and the write data is used directly, so the new lists take effect at the
// same edge as the new weights.
// Assumes a synchronous active-low reset.
module coef_store
    import rpm_pkg::*;
#(
    parameter int unsigned COEF_W = 4,
    parameter int unsigned NTERM  = COEF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_we,
    input  logic [COEF_W-1:0] s_val,
    input  logic              c_we,
    input  logic [COEF_W-1:0] c_val,
    output logic              neg_q   [2],
    output term_t [NTERM-1:0] terms_q [2]
);
    logic [COEF_W-1:0] s_q, c_q, s_nx, c_nx;
    logic              neg_d   [2];
    term_t [NTERM-1:0] terms_d [2];

    // Next weight values: write data or held value, forced to zero in reset.
    always_comb begin
        s_nx = !rst_n ? '0 : (s_we ? s_val : s_q);
        c_nx = !rst_n ? '0 : (c_we ? c_val : c_q);
    end

    // One decomposer per coefficient function.
    for (genvar f = 0; f < 2; f++) begin : g_dec
        coef_decomp #(.COEF_W(COEF_W), .NTERM(NTERM)) u_dec (
            .s_in  (s_nx),
            .c_in  (c_nx),
            .m1    (f[0]),
            .neg   (neg_d[f]),
            .terms (terms_d[f])
        );
    end

    // Load weights and term lists on reset or on any write.
    always_ff @(posedge clk) begin
        if (!rst_n || s_we || c_we) begin
            s_q <= s_nx;
            c_q <= c_nx;
            for (int f = 0; f < 2; f++) begin
                neg_q[f]   <= neg_d[f];
                terms_q[f] <= terms_d[f];
            end
        end
    end

    // R3: term lists hold steady when neither weight is written.
    assert_lists_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_we && !c_we) |=> ($stable(terms_q[0]) && $stable(terms_q[1])
                              && $stable(neg_q[0]) && $stable(neg_q[1])));

    // R4: a negative coefficient is never zero, so its first term is active.
    assert_neg_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_q[0] -> terms_q[0][0].en) && (neg_q[1] -> terms_q[1][0].en));
endmodule

// File: rtl/shift_add_core.sv
// shift_add_core: selects the term list for the requested function,
// shifts the pixel by each active term and sums the terms in an adder
// chain. It negates the sum for a negative coefficient and registers the
// signed result.
// Assumes the sum of the terms fits in PIX_W + COEF_W + 1 bits.
module shift_add_core
    import rpm_pkg::*;
#(
    parameter int unsigned PIX_W  = 8,
    parameter int unsigned COEF_W = 4,
    parameter int unsigned NTERM  = COEF_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [PIX_W-1:0]               pix,
    input  logic                           fsel,
    input  logic                           neg_q   [2],
    input  term_t [NTERM-1:0]              terms_q [2],
    output logic signed [PIX_W+COEF_W+1:0] prod_q
);
    localparam int unsigned SUM_W = PIX_W + COEF_W + 1;
    localparam int unsigned OUT_W = SUM_W + 1;
    localparam int          MAXP  = ((2 ** PIX_W) - 1) * (2 ** COEF_W);

    term_t [NTERM-1:0] sel_terms;
    logic              sel_neg;
    logic [SUM_W-1:0]  shifted [NTERM];
    logic [SUM_W-1:0]  partial [NTERM];
    logic signed [OUT_W-1:0] signed_sum;

    // Function multiplexer: pick one coefficient's term list and sign.
    always_comb begin
        sel_terms = fsel ? terms_q[1] : terms_q[0];
        sel_neg   = fsel ? neg_q[1]   : neg_q[0];
    end

    // Shifters: one per term, zero when the term is unused.
    for (genvar k = 0; k < NTERM; k++) begin : g_shift
        always_comb begin
            shifted[k] = sel_terms[k].en
                       ? ({{(SUM_W-PIX_W){1'b0}}, pix} << sel_terms[k].sh)
                       : '0;
        end
    end

    // Adder chain: NTERM-1 adders accumulate the shifted terms.
    assign partial[0] = shifted[0];
    for (genvar k = 1; k < NTERM; k++) begin : g_add
        assign partial[k] = partial[k-1] + shifted[k];
    end

    // Sign circuit: two's-complement negate for a negative coefficient.
    always_comb begin
        signed_sum = $signed({1'b0, partial[NTERM-1]});
        if (sel_neg) signed_sum = -signed_sum;
    end

    // Output register: one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) prod_q <= '0;
        else        prod_q <= signed_sum;
    end

    // R5: an empty term list means a zero coefficient and a zero product.
    assert_zero_coef_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_terms[0].en) |=> (prod_q == '0));

    // R4: a negative coefficient on a non-zero pixel gives a negative product.
    assert_neg_product_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_neg && pix != '0) |=> prod_q[OUT_W-1]);

    // R1: a non-negative coefficient never gives a negative product.
    assert_pos_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_neg) |=> !prod_q[OUT_W-1]);

    // R8: the product stays within the range the widths allow.
    assert_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(prod_q) <= MAXP) && (int'(prod_q) >= -MAXP));
endmodule

// File: rtl/rpm_unit.sv
// rpm_unit: top of the coefficient shift-add multiplier. It scales an
// unsigned pixel by (S-C) or (S-C-1), with one cycle of latency.
// Assumes S and C are written through their own strobes and that the
// synchronous active-low reset is held for at least one clock edge.
module rpm_unit
    import rpm_pkg::*;
#(
    parameter int unsigned PIX_W  = 8,
    parameter int unsigned COEF_W = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [PIX_W-1:0]               pix_in,
    input  logic                           func_sel,
    input  logic                           s_we,
    input  logic [COEF_W-1:0]              s_val,
    input  logic                           c_we,
    input  logic [COEF_W-1:0]              c_val,
    output logic signed [PIX_W+COEF_W+1:0] prod_out
);
    localparam int unsigned NTERM = COEF_W;

    logic              neg_q   [2];
    term_t [NTERM-1:0] terms_q [2];

    // Weight registers and pre-decomposed term lists.
    coef_store #(.COEF_W(COEF_W), .NTERM(NTERM)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_we    (s_we),
        .s_val   (s_val),
        .c_we    (c_we),
        .c_val   (c_val),
        .neg_q   (neg_q),
        .terms_q (terms_q)
    );

    // Shift, add and sign datapath.
    shift_add_core #(.PIX_W(PIX_W), .COEF_W(COEF_W), .NTERM(NTERM)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix     (pix_in),
        .fsel    (func_sel),
        .neg_q   (neg_q),
        .terms_q (terms_q),
        .prod_q  (prod_out)
    );

    // R7: reset leaves a zero product.
    assert_reset_clear_R7: assert property (@(posedge clk)
        (!rst_n) |=> (prod_out == '0));
endmodule

// File: tb/sim_rpm_unit.sv
module sim_rpm_unit;
    localparam int PIX_W  = 8;
    localparam int COEF_W = 4;
    localparam int OUT_W  = PIX_W + COEF_W + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PIX_W-1:0] pix_in = '0;
    logic func_sel = 1'b0;
    logic s_we = 1'b0, c_we = 1'b0;
    logic [COEF_W-1:0] s_val = '0, c_val = '0;
    logic signed [OUT_W-1:0] prod_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    rpm_unit #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u0 (
        .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .func_sel(func_sel),
        .s_we(s_we), .s_val(s_val), .c_we(c_we), .c_val(c_val),
        .prod_out(prod_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write one or both weights at the next edge (called just after a negedge).
    task automatic write_w(input bit ws, input int sv, input bit wc, input int cv);
        s_we = ws; s_val = COEF_W'(sv);
        c_we = wc; c_val = COEF_W'(cv);
        @(negedge clk);
        s_we = 1'b0; c_we = 1'b0;
    endtask

    // Present a pixel, wait one edge, compare with the model.
    task automatic apply(input string req, input int pix, input bit f, input int exp);
        pix_in = PIX_W'(pix); func_sel = f;
        @(negedge clk);
        chk(req, int'(prod_out), exp);
    endtask

    task automatic t_reset();
        chk("R7 reset", int'(prod_out), 0);
        apply("R7 R5 f0 after reset", 200, 1'b0, 0);
        apply("R7 R4 f1 after reset", 200, 1'b1, -200);
    endtask

    task automatic t_positive();
        write_w(1, 9, 1, 2);
        apply("R1 pos", 37, 1'b0, 7 * 37);
        apply("R2 pos", 37, 1'b1, 6 * 37);
        apply("R8 pix max", 255, 1'b0, 7 * 255);
    endtask

    task automatic t_negative();
        write_w(1, 3, 1, 11);
        apply("R4 f0 neg", 100, 1'b0, -800);
        apply("R4 f1 neg", 100, 1'b1, -900);
    endtask

    task automatic t_zero();
        write_w(1, 6, 1, 6);
        apply("R5 zero a", 1, 1'b0, 0);
        apply("R5 zero b", 255, 1'b0, 0);
        apply("R2 minus one", 77, 1'b1, -77);
    endtask

    task automatic t_extremes();
        write_w(1, 15, 1, 0);
        apply("R6 +15", 255, 1'b0, 3825);
        apply("R6 +14", 255, 1'b1, 3570);
        write_w(1, 0, 1, 15);
        apply("R6 -15", 255, 1'b0, -3825);
        apply("R6 -16", 255, 1'b1, -4080);
        apply("R6 pix zero", 0, 1'b1, 0);
    endtask

    task automatic t_write_order();
        write_w(1, 5, 1, 0);
        pix_in = 8'd10; func_sel = 1'b0;
        s_we = 1'b1; s_val = 4'd10;
        @(negedge clk);
        s_we = 1'b0;
        chk("R3 same-edge old", int'(prod_out), 50);
        @(negedge clk);
        chk("R3 after write new", int'(prod_out), 100);
        write_w(0, 0, 1, 3);
        apply("R3 C only keeps S", 10, 1'b0, 70);
        s_val = 4'd1; c_val = 4'd9;
        apply("R3 no strobe ignored", 10, 1'b0, 70);
    endtask

    task automatic t_sweep();
        int pixs[4] = '{1, 3, 128, 255};
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 16; c++) begin
                write_w(1, s, 1, c);
                for (int p = 0; p < 4; p++) begin
                    apply("R1 sweep", pixs[p], 1'b0, (s - c) * pixs[p]);
                    apply("R2 sweep", pixs[p], 1'b1, (s - c - 1) * pixs[p]);
                end
            end
        end
    endtask

    // Watchdog: a hang counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected<=100000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_positive();
        t_negative();
        t_zero();
        t_extremes();
        t_write_order();
        t_sweep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule